// File: doc/BRIEF.md
# Atomic Bit-Logic Store Engine

This block sits on the bus between one master and a peripheral memory space. It watches the write requests the master issues. When a write carries an operation code in its upper address bits, the block turns that single write into an atomic sequence: it reads the target word, combines it with the write operand by logical AND or logical OR, and writes the result back. The master stays stalled until the write-back is accepted. Software can therefore set or clear bits in a peripheral register with one store instruction, and no other agent can intervene between the read and the write.

Both sides use a single-phase handshake. A transfer completes in the cycle where valid and ready are both high, and read data is returned in that same cycle. Reads, and writes that carry no supported operation, pass straight through with no added latency. The target location is the access address with the decoration bits cleared.

Top module: `rmw_decorator`

## Requirements
- R1: Reads, and writes whose address bits [30:29] are not 2'b10, go to the slave unchanged in the same cycle. Master ready equals slave ready, and master read data equals slave read data. A read whose address looks decorated is also forwarded unchanged.
- R2: A write is decorated when address bits [30:29] equal 2'b10. Bits [28:26] then select the operation: 3'b001 is AND and 3'b010 is OR.
- R3: Both the read and the write-back of a decorated operation use the address ANDed with 32'hE00F_FFFF.
- R4: A decorated write with any other opcode is forwarded in the same cycle as a plain write to the stripped address, with the data and size unchanged.
- R5: A decorated operation uses three stages. In the capture cycle there is no slave access. The next cycle issues the read. The cycle after the read is accepted issues the write-back. No other slave access occurs between the read and the write-back.
- R6: Master ready stays low from the capture cycle until the cycle in which the slave accepts the write-back. Master ready is high in that cycle. With a slave that never stalls, the master transfer takes exactly 3 cycles.
- R7: For an AND operation, each enabled byte lane of the write-back carries the read data ANDed with the write operand.
- R8: For an OR operation, each enabled byte lane of the write-back carries the read data ORed with the write operand.
- R9: The size code is 2'b00 for a byte, 2'b01 for a halfword and 2'b10 for a word. The enabled lanes are those whose lane index, shifted right by the size code, equals address bits [1:0] shifted right by the size code. The lanes that are not enabled carry the unchanged read data. The write-back is issued with the captured size.
- R10: If the slave stalls the read or the write-back, that stage is held, with address and data stable, until the slave accepts it.
- R11: After reset the engine is idle. With no master request, no slave access is made, and master ready follows slave ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mValid | input | 1 | Master request valid |
| mWrite | input | 1 | Master request is a write |
| mAddr | input | 32 | Master address, including the decoration bits |
| mSize | input | 2 | Master transfer size code |
| mWdata | input | 32 | Master write data, replicated across the lanes |
| mReady | output | 1 | Master transfer completes this cycle |
| mRdata | output | 32 | Read data returned to the master |
| sValid | output | 1 | Slave request valid |
| sWrite | output | 1 | Slave request is a write |
| sAddr | output | 32 | Slave address |
| sSize | output | 2 | Slave transfer size code |
| sWdata | output | 32 | Slave write data |
| sReady | input | 1 | Slave accepts the request this cycle |
| sRdata | input | 32 | Slave read data, valid when the slave accepts a read |

## Verification
The release of master ready and the acceptance of the write-back fall in the same cycle. This is where a stall or an early release would break atomicity. The bench provokes it by holding slave ready low for two cycles on every access. It then judges the result by the master's cycle count, the order and addresses of the logged slave accesses, and the final memory contents against a reference model. A second overlap is the capture of a new decorated write, which competes with the passthrough path in the idle cycle. Back-to-back directed writes check that the capture cycle makes no slave access while a plain write in the same idle phase goes straight through.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int SIZE_W = 2;

  localparam logic [1:0] REGION_PERIPH = 2'b10;
  localparam logic [2:0] OPC_AND       = 3'b001;
  localparam logic [2:0] OPC_OR        = 3'b010;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_t;

  typedef struct packed {
    logic capture;
    logic issueRead;
    logic latchResult;
    logic issueWrite;
  } strobe_t;

  function automatic logic isSupportedOp(input logic [4:0] tag);
    return (tag[4:3] == REGION_PERIPH) &&
           ((tag[2:0] == OPC_AND) || (tag[2:0] == OPC_OR));
  endfunction
endpackage

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       mValid,
  input  logic       mWrite,
  input  logic [4:0] mTag,
  input  logic       sReady,
  output strobe_t    str,
  output phase_t     phase,
  output logic       mReady,
  output logic       sValid
);
  phase_t phaseNext;
  logic   engage;

  assign engage = (phase == PH_IDLE) && mValid && mWrite && isSupportedOp(mTag);

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:  if (engage) phaseNext = PH_READ;
      PH_READ:  if (sReady) phaseNext = PH_WRITE;
      PH_WRITE: if (sReady) phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    str.capture     = engage;
    str.issueRead   = (phase == PH_READ);
    str.latchResult = (phase == PH_READ) && sReady;
    str.issueWrite  = (phase == PH_WRITE);
  end

  always_comb begin
    unique case (phase)
      PH_IDLE: begin
        sValid = mValid && !engage;
        mReady = engage ? 1'b0 : sReady;
      end
      PH_READ: begin
        sValid = 1'b1;
        mReady = 1'b0;
      end
      default: begin
        sValid = 1'b1;
        mReady = sReady;
      end
    endcase
  end
endmodule

// File: rtl/rmw_datapath.sv
module rmw_datapath
  import rmw_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] STRIP_MASK = 32'hE00F_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           str,
  input  logic [ADDR_W-1:0] mAddr,
  input  logic              mWrite,
  input  logic [SIZE_W-1:0] mSize,
  input  logic [DATA_W-1:0] mWdata,
  input  logic [DATA_W-1:0] sRdata,
  output logic [ADDR_W-1:0] sAddr,
  output logic              sWrite,
  output logic [SIZE_W-1:0] sSize,
  output logic [DATA_W-1:0] sWdata
);
  localparam int LANES   = DATA_W / 8;
  localparam int LANE_AW = $clog2(LANES);

  logic [ADDR_W-1:0] strippedAddr;
  logic [ADDR_W-1:0] capAddr;
  logic [SIZE_W-1:0] capSize;
  logic              capIsOr;
  logic [DATA_W-1:0] capData;
  logic [DATA_W-1:0] result;
  logic [DATA_W-1:0] merged;
  logic [LANES-1:0]  laneEn;

  assign strippedAddr = mAddr & ADDR_W'(STRIP_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr <= '0;
      capSize <= '0;
      capIsOr <= 1'b0;
      capData <= '0;
    end else if (str.capture) begin
      capAddr <= strippedAddr;
      capSize <= mSize;
      capIsOr <= (mAddr[28:26] == OPC_OR);
      capData <= mWdata;
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      laneEn[i] = ((i >> capSize) == (int'(capAddr[LANE_AW-1:0]) >> capSize));
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] rdLane;
    logic [7:0] opLane;
    assign rdLane = sRdata[g*8 +: 8];
    assign opLane = capData[g*8 +: 8];
    assign merged[g*8 +: 8] = !laneEn[g] ? rdLane :
                              (capIsOr ? (rdLane | opLane) : (rdLane & opLane));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                result <= '0;
    else if (str.latchResult) result <= merged;
  end

  always_comb begin
    if (str.issueRead) begin
      sAddr  = capAddr;
      sWrite = 1'b0;
      sSize  = capSize;
      sWdata = '0;
    end else if (str.issueWrite) begin
      sAddr  = capAddr;
      sWrite = 1'b1;
      sSize  = capSize;
      sWdata = result;
    end else begin
      sAddr  = (mWrite && (mAddr[30:29] == REGION_PERIPH)) ? strippedAddr : mAddr;
      sWrite = mWrite;
      sSize  = mSize;
      sWdata = mWdata;
    end
  end
endmodule

// File: rtl/rmw_decorator.sv
module rmw_decorator
  import rmw_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] STRIP_MASK = 32'hE00F_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mValid,
  input  logic              mWrite,
  input  logic [ADDR_W-1:0] mAddr,
  input  logic [1:0]        mSize,
  input  logic [DATA_W-1:0] mWdata,
  output logic              mReady,
  output logic [DATA_W-1:0] mRdata,
  output logic              sValid,
  output logic              sWrite,
  output logic [ADDR_W-1:0] sAddr,
  output logic [1:0]        sSize,
  output logic [DATA_W-1:0] sWdata,
  input  logic              sReady,
  input  logic [DATA_W-1:0] sRdata
);
  strobe_t str;
  phase_t  phase;

  rmw_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .mValid (mValid),
    .mWrite (mWrite),
    .mTag   (mAddr[30:26]),
    .sReady (sReady),
    .str    (str),
    .phase  (phase),
    .mReady (mReady),
    .sValid (sValid)
  );

  rmw_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .STRIP_MASK (STRIP_MASK)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .str    (str),
    .mAddr  (mAddr),
    .mWrite (mWrite),
    .mSize  (mSize),
    .mWdata (mWdata),
    .sRdata (sRdata),
    .sAddr  (sAddr),
    .sWrite (sWrite),
    .sSize  (sSize),
    .sWdata (sWdata)
  );

  assign mRdata = sRdata;
endmodule

// File: rtl/rmw_checker.sv
module rmw_checker
  import rmw_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] STRIP_MASK = 32'hE00F_FFFF
) (
  input logic              clk,
  input logic              rstN,
  input logic              mValid,
  input logic              mWrite,
  input logic [ADDR_W-1:0] mAddr,
  input logic              mReady,
  input logic [DATA_W-1:0] mRdata,
  input logic              sValid,
  input logic              sWrite,
  input logic [ADDR_W-1:0] sAddr,
  input logic [DATA_W-1:0] sWdata,
  input logic              sReady,
  input logic [DATA_W-1:0] sRdata,
  input phase_t            phase
);
  logic startOp;
  assign startOp = (phase == PH_IDLE) && mValid && mWrite && isSupportedOp(mAddr[30:26]);

  // R5: the capture cycle makes no slave access
  p_capture_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    startOp |-> !sValid);

  // R3: the read following capture targets the stripped address
  p_read_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    startOp |=> (sValid && !sWrite && sAddr == ($past(mAddr) & ADDR_W'(STRIP_MASK))));

  // R5: an accepted read is followed directly by the write-back to the same place
  p_wb_follows_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_READ && sReady) |=> (sValid && sWrite && sAddr == $past(sAddr)));

  // R6: the master is held until the write-back is accepted
  p_master_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((phase != PH_IDLE) && !(phase == PH_WRITE && sReady)) |-> !mReady);

  // R10: a stalled write-back keeps its data
  p_wb_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WRITE && !sReady) |=> (sValid && sWrite && $stable(sWdata) && $stable(sAddr)));

  // R1: plain traffic sees the slave handshake directly
  p_passthru_r1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && mValid && !startOp) |-> (sValid && mReady == sReady && mRdata == sRdata));
endmodule

bind rmw_decorator rmw_checker #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .STRIP_MASK (STRIP_MASK)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .mValid (mValid),
  .mWrite (mWrite),
  .mAddr  (mAddr),
  .mReady (mReady),
  .mRdata (mRdata),
  .sValid (sValid),
  .sWrite (sWrite),
  .sAddr  (sAddr),
  .sWdata (sWdata),
  .sReady (sReady),
  .sRdata (sRdata),
  .phase  (phase)
);

// File: tb/sim_rmw_decorator.sv
`timescale 1ns/1ps
module sim_rmw_decorator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mValid = 1'b0;
  logic        mWrite = 1'b0;
  logic [31:0] mAddr = '0;
  logic [1:0]  mSize = '0;
  logic [31:0] mWdata = '0;
  logic        mReady;
  logic [31:0] mRdata;
  logic        sValid, sWrite, sReady;
  logic [31:0] sAddr, sWdata, sRdata;
  logic [1:0]  sSize;

  int checks = 0;
  int fails  = 0;
  int stallN = 0;
  int waitCnt = 0;
  bit done = 0;

  logic [31:0] mem [16];
  logic [31:0] refMem [16];

  int          logCount = 0;
  logic        logW [8];
  logic [31:0] logA [8];
  logic [31:0] logD [8];
  logic [31:0] logOld [8];

  always #5 clk = ~clk;

  rmw_decorator u0 (
    .clk(clk), .rstN(rstN), .mValid(mValid), .mWrite(mWrite), .mAddr(mAddr),
    .mSize(mSize), .mWdata(mWdata), .mReady(mReady), .mRdata(mRdata),
    .sValid(sValid), .sWrite(sWrite), .sAddr(sAddr), .sSize(sSize),
    .sWdata(sWdata), .sReady(sReady), .sRdata(sRdata)
  );

  function automatic logic [31:0] laneWrite(input logic [31:0] old, input logic [31:0] nw,
                                            input logic [1:0] sz, input logic [1:0] a);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++)
      if ((i >> sz) == (int'(a) >> sz)) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] replicate(input logic [1:0] sz, input logic [31:0] d);
    if (sz == 2'b00) return {4{d[7:0]}};
    if (sz == 2'b01) return {2{d[15:0]}};
    return d;
  endfunction

  // slave model
  assign sReady = (waitCnt >= stallN);
  assign sRdata = mem[sAddr[5:2]];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'hA5C3_0000 + i * 32'h0101_1111;
      waitCnt <= 0;
    end else if (sValid) begin
      if (!sReady) waitCnt <= waitCnt + 1;
      else begin
        waitCnt <= 0;
        logW[logCount % 8]   <= sWrite;
        logA[logCount % 8]   <= sAddr;
        logD[logCount % 8]   <= sWdata;
        logOld[logCount % 8] <= mem[sAddr[5:2]];
        logCount <= logCount + 1;
        if (sWrite) mem[sAddr[5:2]] <= laneWrite(mem[sAddr[5:2]], sWdata, sSize, sAddr[1:0]);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] a, input logic w, input logic [1:0] sz,
                      input logic [31:0] d, output int cyc, output logic [31:0] rd, output int base);
    bit fin;
    @(negedge clk);
    base = logCount;
    mValid = 1'b1; mAddr = a; mWrite = w; mSize = sz; mWdata = d;
    cyc = 0; fin = 0;
    while (!fin && cyc < 100) begin
      #1;
      fin = mReady;
      rd  = mRdata;
      cyc++;
      @(negedge clk);
    end
    mValid = 1'b0; mWrite = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(sValid == 1'b0, "R11 idle no access", {31'b0, sValid}, 32'h0);
    chk(mReady == sReady, "R11 ready follows slave", {31'b0, mReady}, {31'b0, sReady});
  endtask

  task automatic testPassWrite();
    int cyc, base; logic [31:0] rd;
    logic [31:0] a = 32'h2000_0014;
    xfer(a, 1'b1, 2'b10, 32'h1357_9BDF, cyc, rd, base);
    refMem[5] = 32'h1357_9BDF;
    chk(cyc == 1, "R1 plain write latency", cyc, 1);
    chk(logCount - base == 1 && logA[base % 8] == a, "R1 plain write address", logA[base % 8], a);
    chk(mem[5] == refMem[5], "R1 plain write data", mem[5], refMem[5]);
  endtask

  task automatic testPassRead();
    int cyc, base; logic [31:0] rd;
    logic [31:0] a = 32'h4800_0008;
    xfer(a, 1'b0, 2'b10, 32'h0, cyc, rd, base);
    chk(cyc == 1, "R1 read latency", cyc, 1);
    chk(logA[base % 8] == a && logW[base % 8] == 1'b0, "R1 decorated-looking read unchanged", logA[base % 8], a);
    chk(rd == refMem[2], "R1 read data", rd, refMem[2]);
  endtask

  task automatic testUnsupported();
    int cyc, base; logic [31:0] rd;
    logic [31:0] a = 32'h5000_0020;
    xfer(a, 1'b1, 2'b10, 32'h0BAD_F00D, cyc, rd, base);
    refMem[8] = 32'h0BAD_F00D;
    chk(cyc == 1, "R4 unsupported opcode latency", cyc, 1);
    chk(logCount - base == 1 && logA[base % 8] == 32'h4000_0020, "R4 stripped address", logA[base % 8], 32'h4000_0020);
    chk(mem[8] == refMem[8], "R4 plain write data", mem[8], refMem[8]);
  endtask

  task automatic decorated(input logic [2:0] opc, input logic [1:0] sz, input logic [1:0] low,
                           input logic [3:0] word, input logic [31:0] operand, input int expCyc);
    int cyc, base; logic [31:0] rd, rep, old, exp, comb;
    logic [31:0] strip = 32'h4000_0000 | {26'b0, word, low};
    logic [31:0] a = strip | 32'h0010_0000 | ({29'b0, opc} << 26);
    string tag = (opc == 3'b001) ? "R7 AND" : "R8 OR";
    rep = replicate(sz, operand);
    old = refMem[word];
    comb = (opc == 3'b001) ? (old & rep) : (old | rep);
    exp = laneWrite(old, comb, sz, low);
    xfer(a, 1'b1, sz, rep, cyc, rd, base);
    refMem[word] = exp;
    chk(cyc == expCyc, "R6 master stall length", cyc, expCyc);
    chk(logCount - base == 2, "R5 two slave accesses", logCount - base, 2);
    chk(logW[base % 8] == 1'b0 && logW[(base + 1) % 8] == 1'b1, "R5 read then write", {logW[base % 8], logW[(base + 1) % 8]}, 32'h1);
    chk(logA[base % 8] == strip && logA[(base + 1) % 8] == strip, "R3 stripped address", logA[(base + 1) % 8], strip);
    chk(logD[(base + 1) % 8] == laneWrite(old, comb, sz, low), "R9 write-back lanes", logD[(base + 1) % 8], exp);
    chk(mem[word] == exp, tag, mem[word], exp);
  endtask

  task automatic testAndOr();
    logic [31:0] pat;
    for (int op = 1; op <= 2; op++) begin
      for (int k = 0; k < 7; k++) begin
        logic [1:0] sz = (k < 4) ? 2'b00 : ((k < 6) ? 2'b01 : 2'b10);
        logic [1:0] low = (k < 4) ? 2'(k) : ((k == 5) ? 2'b10 : 2'b00);
        pat = 32'h3C96_F00F ^ (32'(k) * 32'h1111_0F0F) ^ (32'(op) << 7);
        decorated(3'(op), sz, low, 4'(3 + k), pat, 3);
      end
    end
  endtask

  task automatic testStall();
    stallN = 2;
    decorated(3'b010, 2'b01, 2'b10, 4'd12, 32'h8001_8001, 7);
    decorated(3'b001, 2'b00, 2'b01, 4'd13, 32'h0000_5A00, 7);
    stallN = 0;
  endtask

  task automatic testBackToBack();
    int cyc, base; logic [31:0] rd;
    decorated(3'b010, 2'b10, 2'b00, 4'd14, 32'h00FF_0000, 3);
    xfer(32'h2000_0038, 1'b1, 2'b10, 32'hCAFE_0001, cyc, rd, base);
    refMem[14] = 32'hCAFE_0001;
    chk(cyc == 1 && mem[14] == refMem[14], "R2 plain write after decorated", mem[14], refMem[14]);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) refMem[i] = 32'hA5C3_0000 + i * 32'h0101_1111;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPassWrite();
    testPassRead();
    testUnsupported();
    testAndOr();
    testStall();
    testBackToBack();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule